// File: doc/BRIEF.md
# PHY Management Port Controller

This block is the management side of an Ethernet MAC. It talks to external PHY devices over a two-wire serial management bus (MDC clock, bidirectional MDIO data) and has three ways of working. In frame mode, software writes one 32-bit command word. The engine then sends a complete Clause-22 read or write transaction, and the command word doubles as the place where completion and read data come back. In poll mode, the engine reads one chosen PHY register again and again. Every bit that flips between two reads is recorded in a sticky change register, and a mask decides which of those changes raise the interrupt. In bit-bang mode, the hardware sequencer is bypassed and three one-bit registers drive the clock, the data output and the output enable directly.

Software uses a simple register port: write strobe, read strobe, 3-bit word address and 32-bit data. The port reads without wait states, and a read of the change register is also its clear. The MDIO line is presented as separate out, output-enable and in signals, so the pad ring builds the tri-state buffer.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset the config register (address 0) reads 0, the command register (address 1) reads 0x00010000, the change register (address 5) reads 0, and mdc, mdioOe and irq are 0.
- R2: Writing the command register with bits [29:28]=01 sends a write transaction of 64 MDC cycles. The order on the wire is: 32 ones, then 01, then 01, then the PHY address from bits [27:23], then the register address from bits [22:18], then 10, then bits [15:0] MSB first. mdioOe stays high throughout.
- R3: Bits [29:28]=10 send a read transaction with the same layout and opcode 10. mdioOe is high for the first 46 bits and low from the turnaround to the end. The 16 data bits are sampled on MDC rising edges, MSB first, and land in command register bits [15:0].
- R4: Command register bit 16 reads 0 from an accepted command write until its transaction ends, and 1 after that. For a write, bits [15:0] keep the written data.
- R5: With config bits [23:16] = N, MDC stays high for N system clocks and low for N system clocks while a transaction runs. N=0 behaves as N=1. Outside transactions in frame mode MDC does not toggle.
- R6: In frame mode mdioOut changes only while MDC is low, so it is stable at each MDC rising edge.
- R7: A command write is ignored, leaving the command register unchanged and starting no transaction, in three cases: its opcode is 00 or 11; a command transaction is still pending or running; or bit-bang mode is selected.
- R8: With config bit 1 set, mdc, mdioOut and mdioOe follow bit 0 of registers 2, 3 and 4. Writing 1 after 0 to register 2 gives a rising MDC edge. Register 3 reads mdioIn in bit 1.
- R9: With config bit 0 set and bit 1 clear, the engine keeps reading PHY config[14:10], register config[7:3]. The first read after enabling only sets the reference value. Each later read ORs (new XOR previous) into the change register.
- R10: A read of the change register returns its value and clears it. Bits set in that same cycle are kept.
- R11: irq is high exactly when a change register bit is set whose bit in the mask register (address 6) is 1.
- R12: A command written while a poll read is running is kept and sent as soon as that read ends, before the next poll read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (clears change register at address 5) |
| regAddr | input | 3 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from address |
| mdc | output | 1 | Management clock to PHY |
| mdioOut | output | 1 | MDIO output value |
| mdioOe | output | 1 | MDIO driver enable |
| mdioIn | input | 1 | MDIO value seen at the pad |
| irq | output | 1 | Masked change interrupt |

## Verification
The bench goes after the turnaround boundary of a read. A design that released the line one bit late would fight the PHY, and one that sampled one edge early would return the data shifted by one bit. It uses the divider value 0 and an odd divider: an off-by-one divider shows up as a wrong measured MDC period. It also writes a second command while the first is still outstanding. A design that accepted that write would corrupt the command register and send two transactions. For poll mode, the bench changes the PHY value exactly at transaction boundaries and checks three things: the first read must not report a change, a masked-off change must be recorded without raising irq, and a read-clear must not lose later changes.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] REG_CFG    = 3'd0;
  localparam logic [ADDR_W-1:0] REG_FRAME  = 3'd1;
  localparam logic [ADDR_W-1:0] REG_BBCLK  = 3'd2;
  localparam logic [ADDR_W-1:0] REG_BBDATA = 3'd3;
  localparam logic [ADDR_W-1:0] REG_BBOE   = 3'd4;
  localparam logic [ADDR_W-1:0] REG_STATUS = 3'd5;
  localparam logic [ADDR_W-1:0] REG_MASK   = 3'd6;

  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  // strobes and operands from control to datapath
  typedef struct packed {
    logic              start;
    logic              isRead;
    logic [4:0]        phyAd;
    logic [4:0]        regAd;
    logic [DATA_W-1:0] wrData;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_datapath.sv
`timescale 1ns/1ps
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int PRE_BITS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  mdio_cmd_t         cmd,
  input  logic [DIV_W-1:0]  halfDiv,
  input  logic              mdioIn,
  output logic              busy,
  output logic              doneTick,
  output logic [DATA_W-1:0] rdData,
  output logic              mdcOut,
  output logic              mdoOut,
  output logic              oeOut
);
  localparam int FRAME_LEN  = PRE_BITS + 32;
  localparam int IDX_W      = $clog2(FRAME_LEN);
  localparam int HDR_END    = PRE_BITS + 14;
  localparam int DATA_START = PRE_BITS + 16;

  logic [FRAME_LEN-1:0] shiftQ;
  logic [IDX_W-1:0]     idxQ;
  logic [DIV_W-1:0]     divCntQ;
  logic                 activeQ, mdcQ, isReadQ, doneQ;
  logic [DATA_W-1:0]    rdQ;

  logic [DIV_W-1:0]     halfEff;
  logic                 lastTick;
  logic [1:0]           opBits, taBits;
  logic [DATA_W-1:0]    dataBits;
  logic [FRAME_LEN-1:0] frameInit;

  always_comb begin
    halfEff   = (halfDiv == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : halfDiv;
    lastTick  = divCntQ >= (halfEff - 1'b1);
    opBits    = cmd.isRead ? OP_READ : OP_WRITE;
    taBits    = cmd.isRead ? 2'b11 : 2'b10;
    dataBits  = cmd.isRead ? '1 : cmd.wrData;
    frameInit = {{PRE_BITS{1'b1}}, 2'b01, opBits, cmd.phyAd, cmd.regAd, taBits, dataBits};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ  <= '0;
      idxQ    <= '0;
      divCntQ <= '0;
      activeQ <= 1'b0;
      mdcQ    <= 1'b0;
      isReadQ <= 1'b0;
      doneQ   <= 1'b0;
      rdQ     <= '0;
    end else begin
      doneQ <= 1'b0;
      if (!activeQ) begin
        if (cmd.start) begin
          activeQ <= 1'b1;
          shiftQ  <= frameInit;
          idxQ    <= '0;
          divCntQ <= '0;
          mdcQ    <= 1'b0;
          isReadQ <= cmd.isRead;
          rdQ     <= '0;
        end
      end else if (lastTick) begin
        divCntQ <= '0;
        if (!mdcQ) begin
          // rising edge: sample returned data
          mdcQ <= 1'b1;
          if (isReadQ && idxQ >= IDX_W'(DATA_START))
            rdQ <= {rdQ[DATA_W-2:0], mdioIn};
        end else begin
          // falling edge: advance to next bit
          mdcQ <= 1'b0;
          if (idxQ == IDX_W'(FRAME_LEN - 1)) begin
            activeQ <= 1'b0;
            doneQ   <= 1'b1;
          end else begin
            idxQ   <= idxQ + 1'b1;
            shiftQ <= {shiftQ[FRAME_LEN-2:0], 1'b0};
          end
        end
      end else begin
        divCntQ <= divCntQ + 1'b1;
      end
    end
  end

  assign busy     = activeQ;
  assign doneTick = doneQ;
  assign rdData   = rdQ;
  assign mdcOut   = mdcQ;
  assign mdoOut   = activeQ ? shiftQ[FRAME_LEN-1] : 1'b1;
  assign oeOut    = activeQ && (!isReadQ || idxQ < IDX_W'(HDR_END));
endmodule

// File: rtl/mdio_ctrl.sv
`timescale 1ns/1ps
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              mdioIn,
  input  logic              dpBusy,
  input  logic              dpDone,
  input  logic [DATA_W-1:0] dpRdData,
  output mdio_cmd_t         cmd,
  output logic [DIV_W-1:0]  halfDiv,
  output logic              bbSel,
  output logic              bbClk,
  output logic              bbData,
  output logic              bbOe,
  output logic              irq
);
  logic              cfgPollEn, cfgBitBang;
  logic [4:0]        cfgPollReg, cfgPollPhy;
  logic [DIV_W-1:0]  cfgHalfDiv;
  logic [31:17]      frameHiQ;
  logic [15:0]       frameLoQ;
  logic              frameDoneQ, framePendQ, curPollQ;
  logic              bbClkQ, bbDataQ, bbOeQ;
  logic [DATA_W-1:0] pollStatusQ, pollMaskQ, pollLastQ;
  logic              pollBaseQ;

  logic              frameOutstanding, frameOpOk, frameAccept;
  logic              canStart, startFrame, statusClr;
  logic [DATA_W-1:0] statusSet;

  function automatic logic wrHit(input logic [ADDR_W-1:0] a);
    return regWrEn && (regAddr == a);
  endfunction

  always_comb begin
    frameOutstanding = framePendQ || (dpBusy && !curPollQ);
    frameOpOk   = (regWrData[29:28] == OP_READ) || (regWrData[29:28] == OP_WRITE);
    frameAccept = wrHit(REG_FRAME) && !cfgBitBang && !frameOutstanding && frameOpOk;
    canStart    = !dpBusy && !cfgBitBang && (framePendQ || cfgPollEn);
    startFrame  = canStart && framePendQ;
    statusClr   = regRdEn && (regAddr == REG_STATUS);
    statusSet   = (dpDone && curPollQ && cfgPollEn && pollBaseQ) ? (dpRdData ^ pollLastQ) : '0;

    cmd.start  = canStart;
    cmd.isRead = startFrame ? (frameHiQ[29:28] == OP_READ) : 1'b1;
    cmd.phyAd  = startFrame ? frameHiQ[27:23] : cfgPollPhy;
    cmd.regAd  = startFrame ? frameHiQ[22:18] : cfgPollReg;
    cmd.wrData = frameLoQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgPollEn   <= 1'b0;
      cfgBitBang  <= 1'b0;
      cfgPollReg  <= '0;
      cfgPollPhy  <= '0;
      cfgHalfDiv  <= '0;
      frameHiQ    <= '0;
      frameLoQ    <= '0;
      frameDoneQ  <= 1'b1;
      framePendQ  <= 1'b0;
      curPollQ    <= 1'b0;
      bbClkQ      <= 1'b0;
      bbDataQ     <= 1'b0;
      bbOeQ       <= 1'b0;
      pollStatusQ <= '0;
      pollMaskQ   <= '0;
      pollLastQ   <= '0;
      pollBaseQ   <= 1'b0;
    end else begin
      if (wrHit(REG_CFG)) begin
        cfgPollEn  <= regWrData[0];
        cfgBitBang <= regWrData[1];
        cfgPollReg <= regWrData[7:3];
        cfgPollPhy <= regWrData[14:10];
        cfgHalfDiv <= regWrData[16 +: DIV_W];
      end
      if (wrHit(REG_BBCLK))  bbClkQ    <= regWrData[0];
      if (wrHit(REG_BBDATA)) bbDataQ   <= regWrData[0];
      if (wrHit(REG_BBOE))   bbOeQ     <= regWrData[0];
      if (wrHit(REG_MASK))   pollMaskQ <= regWrData[DATA_W-1:0];

      // completion of the running transaction
      if (dpDone) begin
        if (curPollQ) begin
          if (cfgPollEn) begin
            pollLastQ <= dpRdData;
            pollBaseQ <= 1'b1;
          end
        end else begin
          frameDoneQ <= 1'b1;
          if (frameHiQ[29:28] == OP_READ) frameLoQ <= dpRdData;
        end
      end
      if (!cfgPollEn) pollBaseQ <= 1'b0;

      // launch: a pending command wins over the next poll
      if (canStart) begin
        curPollQ <= !framePendQ;
        if (framePendQ) framePendQ <= 1'b0;
      end

      if (frameAccept) begin
        frameHiQ   <= regWrData[31:17];
        frameLoQ   <= regWrData[15:0];
        frameDoneQ <= 1'b0;
        framePendQ <= 1'b1;
      end

      pollStatusQ <= (statusClr ? '0 : pollStatusQ) | statusSet;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_CFG: begin
        regRdData[0]           = cfgPollEn;
        regRdData[1]           = cfgBitBang;
        regRdData[7:3]         = cfgPollReg;
        regRdData[14:10]       = cfgPollPhy;
        regRdData[16 +: DIV_W] = cfgHalfDiv;
      end
      REG_FRAME:  regRdData = {frameHiQ, frameDoneQ, frameLoQ};
      REG_BBCLK:  regRdData[0] = bbClkQ;
      REG_BBDATA: regRdData[1:0] = {mdioIn, bbDataQ};
      REG_BBOE:   regRdData[0] = bbOeQ;
      REG_STATUS: regRdData[DATA_W-1:0] = pollStatusQ;
      REG_MASK:   regRdData[DATA_W-1:0] = pollMaskQ;
      default:    regRdData = '0;
    endcase
  end

  assign halfDiv = cfgHalfDiv;
  assign bbSel   = cfgBitBang;
  assign bbClk   = bbClkQ;
  assign bbData  = bbDataQ;
  assign bbOe    = bbOeQ;
  assign irq     = |(pollStatusQ & pollMaskQ);
endmodule

// File: rtl/mdio_mgmt.sv
`timescale 1ns/1ps
module mdio_mgmt
  import mdio_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn,
  output logic        irq
);
  mdio_cmd_t         cmd;
  logic [DIV_W-1:0]  halfDiv;
  logic              dpBusy, dpDone, dpMdc, dpMdo, dpOe;
  logic [DATA_W-1:0] dpRdData;
  logic              bbSel, bbClk, bbData, bbOe;

  mdio_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .mdioIn(mdioIn), .dpBusy(dpBusy), .dpDone(dpDone), .dpRdData(dpRdData),
    .cmd(cmd), .halfDiv(halfDiv), .bbSel(bbSel), .bbClk(bbClk),
    .bbData(bbData), .bbOe(bbOe), .irq(irq)
  );

  mdio_datapath #(.DIV_W(DIV_W), .PRE_BITS(PRE_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .halfDiv(halfDiv), .mdioIn(mdioIn),
    .busy(dpBusy), .doneTick(dpDone), .rdData(dpRdData),
    .mdcOut(dpMdc), .mdoOut(dpMdo), .oeOut(dpOe)
  );

  assign mdc     = bbSel ? bbClk  : dpMdc;
  assign mdioOut = bbSel ? bbData : dpMdo;
  assign mdioOe  = bbSel ? bbOe   : dpOe;
endmodule

// File: rtl/mdio_mgmt_checker.sv
`timescale 1ns/1ps
module mdio_mgmt_checker #(
  parameter int IDX_W    = 6,
  parameter int PRE_BITS = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic             regRdEn,
  input logic [2:0]       regAddr,
  input logic             mdc,
  input logic             mdioOut,
  input logic             mdioOe,
  input logic             irq,
  input logic             bbSel,
  input logic             dpBusy,
  input logic             dpDone,
  input logic             dpIsRead,
  input logic [IDX_W-1:0] dpIdx,
  input logic [15:0]      pollStatus
);
  localparam logic [IDX_W-1:0] TA_IDX = IDX_W'(PRE_BITS + 14);

  // R3: line released from turnaround onward in a read
  a_r3_release_on_read: assert property (@(posedge clk) disable iff (!rstN)
    (!bbSel && dpBusy && dpIsRead && dpIdx >= TA_IDX) |-> !mdioOe);

  // R5: frame-mode clock only moves while a transaction runs
  a_r5_mdc_only_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!bbSel && !$past(bbSel) && mdc != $past(mdc)) |-> $past(dpBusy));

  // R6: data changes only with MDC low
  a_r6_data_on_low_clock: assert property (@(posedge clk) disable iff (!rstN)
    (!bbSel && !$past(bbSel) && mdioOut != $past(mdioOut)) |-> !mdc);

  // R8: in bit-bang mode MDC moves only after a clock-register write
  a_r8_bb_clock_by_write: assert property (@(posedge clk) disable iff (!rstN)
    (bbSel && $past(bbSel) && mdc != $past(mdc)) |-> $past(regWrEn && regAddr == 3'd2));

  // R10: a read of the change register leaves it empty unless a poll just completed
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    ($past(regRdEn && regAddr == 3'd5) && !$past(dpDone)) |-> (pollStatus == 16'h0));

  // R11: interrupt rises only after a completion or a mask write
  a_r11_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(dpDone) || $past(regWrEn && regAddr == 3'd6)));
endmodule

bind mdio_mgmt mdio_mgmt_checker u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
  .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .irq(irq), .bbSel(bbSel),
  .dpBusy(dpBusy), .dpDone(dpDone), .dpIsRead(u_dp.isReadQ), .dpIdx(u_dp.idxQ),
  .pollStatus(u_ctrl.pollStatusQ)
);

// File: tb/mdio_mgmt_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        mdc, mdioOut, mdioOe, mdioIn, irq;

  logic        bbTest = 1'b0, bbIn = 1'b0, phyBit = 1'b1;
  logic [15:0] phyVal = 16'h0;
  logic [63:0] capBits = '0, capOe = '0, lastBits = '0, lastOe = '0;
  logic        mdoAtRise = 1'b1;
  int          riseCnt = 0, frameCount = 0, r6Viol = 0;
  int          nChecks = 0, nFail = 0;
  event        frameEnd;

  always #2.5 clk = ~clk;
  assign mdioIn = bbTest ? bbIn : phyBit;

  mdio_mgmt u_mdio_mgmt (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .mdioIn(mdioIn), .irq(irq)
  );

  // PHY model: records each 64-bit transaction, returns phyVal on reads
  always @(posedge mdc) if (!bbTest) begin
    capBits   = {capBits[62:0], mdioOut};
    capOe     = {capOe[62:0], mdioOe};
    mdoAtRise = mdioOut;
    riseCnt++;
    if (riseCnt == 64) begin
      riseCnt = 0; lastBits = capBits; lastOe = capOe; frameCount++;
      -> frameEnd;
    end
  end
  always @(negedge mdc) if (!bbTest) begin
    if (riseCnt >= 48) phyBit = phyVal[63-riseCnt];
    else phyBit = 1'b1;
  end
  always @(negedge clk) if (!bbTest && mdc && mdioOut !== mdoAtRise) r6Viol++;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); regRdEn = 1'b1; regAddr = a; #1 d = regRdData;
    @(negedge clk); regRdEn = 1'b0;
  endtask

  task automatic waitDone(output logic [31:0] d);
    for (int i = 0; i < 20000; i++) begin
      regRead(3'd1, d);
      if (d[16]) return;
    end
    chk("R4 done timeout", {63'b0, d[16]}, 64'd1);
  endtask

  function automatic logic [31:0] cmdWord(input logic [1:0] op, input logic [4:0] phy,
                                          input logic [4:0] rg, input logic [15:0] dat);
    return {2'b01, op, phy, rg, 2'b00, dat};
  endfunction

  function automatic logic [63:0] expBits(input logic rd, input logic [4:0] phy,
                                          input logic [4:0] rg, input logic [15:0] dat);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg, 2'b10, dat};
  endfunction

  function automatic logic [63:0] expOe(input logic rd);
    return rd ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
  endfunction

  function automatic logic [31:0] cfgWord(input logic pollEn, input logic bb, input logic [4:0] prg,
                                          input logic [4:0] pphy, input logic [7:0] div);
    return {8'b0, div, 1'b0, pphy, 2'b0, prg, 1'b0, bb, pollEn};
  endfunction

  task automatic runFrame(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] dat, input string tag);
    logic [31:0] d;
    logic [63:0] e;
    regWrite(3'd1, cmdWord(rd ? 2'b10 : 2'b01, phy, rg, dat));
    waitDone(d);
    e = expBits(rd, phy, rg, dat);
    if (rd) begin
      chk({tag, " R3 header"}, {18'b0, lastBits[63:18]}, {18'b0, e[63:18]});
      chk({tag, " R3 oe"}, lastOe, expOe(1'b1));
      chk({tag, " R3 data"}, {48'b0, d[15:0]}, {48'b0, phyVal});
    end else begin
      chk({tag, " R2 bits"}, lastBits, e);
      chk({tag, " R2 oe"}, lastOe, expOe(1'b0));
      chk({tag, " R4 data kept"}, {48'b0, d[15:0]}, {48'b0, dat});
    end
  endtask

  task automatic measureDiv(input logic [7:0] div);
    realtime t1, t2, t3;
    int eff;
    logic [31:0] d;
    eff = (div == 0) ? 1 : div;
    regWrite(3'd0, cfgWord(1'b0, 1'b0, 5'd0, 5'd0, div));
    regWrite(3'd1, cmdWord(2'b01, 5'd1, 5'd2, 16'h5555));
    @(posedge mdc); t1 = $realtime;
    @(negedge mdc); t2 = $realtime;
    @(posedge mdc); t3 = $realtime;
    chk("R5 high time", 64'(int'(t2 - t1)), 64'(eff * 5));
    chk("R5 period", 64'(int'(t3 - t1)), 64'(eff * 10));
    waitDone(d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] d, first, second;
    int fc0;
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    chk("R1 mdc", {63'b0, mdc}, 64'd0);
    chk("R1 oe", {63'b0, mdioOe}, 64'd0);
    chk("R1 irq", {63'b0, irq}, 64'd0);
    regRead(3'd0, d); chk("R1 cfg", {32'b0, d}, 64'h0);
    regRead(3'd1, d); chk("R1 frame", {32'b0, d}, 64'h0001_0000);
    regRead(3'd5, d); chk("R1 status", {32'b0, d}, 64'h0);

    // R2/R3/R4 directed
    regWrite(3'd0, cfgWord(1'b0, 1'b0, 5'd0, 5'd0, 8'd2));
    regWrite(3'd1, cmdWord(2'b01, 5'h1F, 5'h00, 16'hA5C3));
    regRead(3'd1, d); chk("R4 busy reads 0", {63'b0, d[16]}, 64'd0);
    waitDone(d);
    chk("R2 write bits", lastBits, expBits(1'b0, 5'h1F, 5'h00, 16'hA5C3));
    chk("R2 write oe", lastOe, expOe(1'b0));
    chk("R4 done", {32'b0, d}, {32'b0, cmdWord(2'b01, 5'h1F, 5'h00, 16'hA5C3) | 32'h0001_0000});
    phyVal = 16'h8001;
    runFrame(1'b1, 5'h00, 5'h1F, 16'h0, "directed read");
    phyVal = 16'h1234;
    runFrame(1'b1, 5'h0A, 5'h05, 16'h0, "directed read2");

    // R5 divider
    measureDiv(8'd3);
    measureDiv(8'd0);
    measureDiv(8'd1);

    // random transactions
    for (int i = 0; i < 8; i++) begin
      logic rd;
      rd = $urandom_range(0, 1);
      phyVal = 16'($urandom);
      regWrite(3'd0, cfgWord(1'b0, 1'b0, 5'd0, 5'd0, 8'($urandom_range(1, 3))));
      runFrame(rd, 5'($urandom), 5'($urandom), 16'($urandom), "random");
    end

    // R7 ignored writes
    regRead(3'd1, first);
    regWrite(3'd1, cmdWord(2'b00, 5'd3, 5'd3, 16'h1111));
    regRead(3'd1, d); chk("R7 op 00 ignored", {32'b0, d}, {32'b0, first});
    regWrite(3'd1, cmdWord(2'b11, 5'd3, 5'd3, 16'h2222));
    regRead(3'd1, d); chk("R7 op 11 ignored", {32'b0, d}, {32'b0, first});
    fc0 = frameCount;
    first  = cmdWord(2'b01, 5'd7, 5'd9, 16'hBEEF);
    second = cmdWord(2'b01, 5'd8, 5'd4, 16'hCAFE);
    regWrite(3'd1, first);
    regWrite(3'd1, second);
    regRead(3'd1, d); chk("R7 outstanding ignored", {32'b0, d}, {32'b0, first});
    waitDone(d);
    repeat (400) @(posedge clk);
    chk("R7 single transaction", 64'(frameCount - fc0), 64'd1);
    chk("R7 first sent", lastBits, expBits(1'b0, 5'd7, 5'd9, 16'hBEEF));

    // R6 data stable across high clock
    chk("R6 no change while high", 64'(r6Viol), 64'd0);

    // R9/R10/R11 poll
    phyVal = 16'h00F0;
    regWrite(3'd6, 32'h0000_0F0E);
    regWrite(3'd0, cfgWord(1'b1, 1'b0, 5'd7, 5'h12, 8'd1));
    @(frameEnd); @(frameEnd);
    chk("R9 poll header", {18'b0, lastBits[63:18]}, {18'b0, expBits(1'b1, 5'h12, 5'd7, 16'h0) >> 18});
    regRead(3'd5, d); chk("R9 baseline no change", {32'b0, d}, 64'h0);
    @(frameEnd); phyVal = 16'h0FF0;
    @(frameEnd); @(frameEnd);
    @(negedge clk);
    chk("R11 irq on masked-in change", {63'b0, irq}, 64'd1);
    regRead(3'd5, d); chk("R9 change bits", {32'b0, d}, 64'h0F00);
    regRead(3'd5, d); chk("R10 cleared on read", {32'b0, d}, 64'h0);
    @(negedge clk);
    chk("R11 irq drops", {63'b0, irq}, 64'd0);
    @(frameEnd); phyVal = 16'h0FF1;
    @(frameEnd); @(frameEnd);
    @(negedge clk);
    chk("R11 masked-out no irq", {63'b0, irq}, 64'd0);
    regRead(3'd5, d); chk("R9 masked change recorded", {32'b0, d}, 64'h0001);

    // R12 command during polling
    regWrite(3'd1, cmdWord(2'b01, 5'd21, 5'd13, 16'h0F5A));
    waitDone(d);
    chk("R12 command sent between polls", lastBits, expBits(1'b0, 5'd21, 5'd13, 16'h0F5A));
    regWrite(3'd0, cfgWord(1'b0, 1'b0, 5'd0, 5'd0, 8'd1));
    repeat (300) @(posedge clk);

    // R8 bit-bang
    bbTest = 1'b1;
    regRead(3'd1, first);
    regWrite(3'd0, cfgWord(1'b0, 1'b1, 5'd0, 5'd0, 8'd1));
    regWrite(3'd2, 32'd0);
    chk("R8 clock low", {63'b0, mdc}, 64'd0);
    regWrite(3'd2, 32'd1);
    chk("R8 clock rises", {63'b0, mdc}, 64'd1);
    regWrite(3'd3, 32'd1);
    chk("R8 data 1", {63'b0, mdioOut}, 64'd1);
    regWrite(3'd3, 32'd0);
    chk("R8 data 0", {63'b0, mdioOut}, 64'd0);
    regWrite(3'd4, 32'd1);
    chk("R8 oe", {63'b0, mdioOe}, 64'd1);
    bbIn = 1'b1;
    regRead(3'd3, d); chk("R8 input read 1", {62'b0, d[1:0]}, 64'd2);
    bbIn = 1'b0;
    regRead(3'd3, d); chk("R8 input read 0", {62'b0, d[1:0]}, 64'd0);
    regWrite(3'd1, cmdWord(2'b01, 5'd1, 5'd1, 16'h7777));
    regRead(3'd1, d); chk("R7 bit-bang ignores command", {32'b0, d}, {32'b0, first});

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule